// File: doc/BRIEF.md
# PWM Timer Tick Source

This block turns one base clock into five tick-enable pulses, one per PWM timer channel. Each tick is a single base-clock cycle wide and marks the moment a channel counter would step. The block makes no derived clocks. Every output is an enable in the base clock domain.

Two 8-bit prescalers share the work unequally. The low prescaler serves channels 0 and 1, and the high prescaler serves channels 2, 3 and 4. Each channel then has a 4-bit selector. The selector either picks a power-of-two division of its group's prescaler pulse or picks an external timer clock. That external clock is synchronised into the base domain and turned into one tick per rising edge. Channels 0–1 use external clock 0 and channels 2–4 use external clock 1. The block holds no configuration state of its own. It reads two configuration words every cycle, so a register file elsewhere supplies them.

Top module: `pwm_tick_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, all five tick outputs are low.
- R2: Bits 7:0 of the prescale word set the prescale value P of channels 0–1, and bits 15:8 set it for channels 2–4. A prescaler divides the base clock by P+1, so P = 0 passes every base cycle.
- R3: Bits 4c+3:4c of the select word hold the 4-bit selector code of channel c.
- R4: A divider code n that is not external gives a tick period of (P+1)·2^(n+DIV_BASE) base cycles. The default DIV_BASE is 1, so code 0 divides by 2.
- R5: A selector code whose bit is set in EXT_MASK selects an external clock. With the default mask only code 4 is external. Channels 0–1 follow external clock 0 and channels 2–4 follow external clock 1. The prescale value then has no effect on that channel.
- R6: An external clock passes through a two-flop synchroniser and a rising-edge detector. Each rising edge gives exactly one tick, so the tick period equals the external clock period.
- R7: A non-external code whose division would exceed 2^DIV_MAX_LOG2 (16 by default) is clamped to that division. With default parameters codes 3 and 5–15 all divide by 16.
- R8: Every tick is high for exactly one base cycle when the division is at least 2.
- R9: A change on a prescale field or on a channel's selector restarts the affected counters from zero at the next base clock edge E0, and that edge produces no tick. If the prescaler did not change and P = 0, the first tick then arrives at edge E0 + (P+1)·2^(n+DIV_BASE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 16 | Two prescale values: channels 0–1 in the low byte, channels 2–4 in the high byte |
| cfg_select | input | 20 | One 4-bit selector code per channel, channel c at bit 4c |
| ext_clk0 | input | 1 | External timer clock for channels 0–1, asynchronous |
| ext_clk1 | input | 1 | External timer clock for channels 2–4, asynchronous |
| tick | output | 5 | Single-cycle tick enables, bit c for channel c |

## Verification
The tick period is measured on every channel under five configuration vectors. The first has every division at its minimum. The second mixes codes so that each channel has a different period, which exposes a swapped selector field or a wrong power of two. The third puts external clocks of different periods on both groups while the prescalers are nonzero. The fourth uses out-of-range codes that must clamp. The fifth uses unequal prescalers with equal codes, which exposes a swapped prescaler group. Directed tests then count the exact cycle of the first tick after a selector-only change and after a prescaler change, and check the reset state.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  typedef enum logic {
    SRC_DIVIDER  = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;

  localparam int unsigned SYNC_DEPTH = 2;

  // prescaler group owning a channel: channels below split use group 0
  function automatic int unsigned group_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

endpackage

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_i,
  output logic             restart_o,
  output logic             pulse_o
);

  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    restart_o = (psc_i != psc_q);
    pulse_o   = !restart_o && (cnt_q == psc_q);
    psc_d     = psc_i;
    if (restart_o) begin
      cnt_d = '0;
    end else if (pulse_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else begin
      psc_q <= psc_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: count never passes the active prescale value
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= psc_q);

  // R9: a new prescale value clears the count on the next edge
  a_r9_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (cnt_q == '0));

endmodule

// File: rtl/ptg_ext_sync.sv
module ptg_ext_sync
  import pwm_tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic rise_o
);

  logic [SYNC_DEPTH:0] sh_q, sh_d;

  always_comb begin
    sh_d   = {sh_q[SYNC_DEPTH-1:0], ext_i};
    rise_o = sh_q[SYNC_DEPTH-1] && !sh_q[SYNC_DEPTH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  // R6: one detected edge never lasts two cycles
  a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ptg_chan_div.sv
module ptg_chan_div
  import pwm_tick_pkg::*;
#(
  parameter int unsigned SEL_W        = 4,
  parameter int unsigned DIV_BASE     = 1,
  parameter int unsigned DIV_MAX_LOG2 = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pre_pulse_i,
  input  logic             pre_restart_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);

  localparam int unsigned CW  = DIV_MAX_LOG2;
  localparam int unsigned SHW = SEL_W + 2;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CW-1:0]    dcnt_q, dcnt_d;
  logic             tick_q, tick_d;
  logic             restart;
  tick_src_e        src;
  logic [SHW-1:0]   shift_raw;
  logic [SHW-1:0]   shift;
  logic [CW:0]      weight;
  logic [CW-1:0]    lim;
  logic             div_hit;

  always_comb begin
    src       = EXT_MASK[sel_q] ? SRC_EXTERNAL : SRC_DIVIDER;
    shift_raw = SHW'(sel_q) + SHW'(DIV_BASE);
    shift     = (shift_raw > SHW'(CW)) ? SHW'(CW) : shift_raw;
    weight    = (CW+1)'(1) << shift;
    lim       = weight[CW-1:0] - CW'(1);
    restart   = (sel_i != sel_q) || pre_restart_i;
    div_hit   = pre_pulse_i && (dcnt_q == lim);
    sel_d     = sel_i;

    if (restart) begin
      dcnt_d = '0;
    end else if (pre_pulse_i) begin
      dcnt_d = div_hit ? '0 : (dcnt_q + CW'(1));
    end else begin
      dcnt_d = dcnt_q;
    end

    if (restart) begin
      tick_d = 1'b0;
    end else if (src == SRC_EXTERNAL) begin
      tick_d = ext_rise_i;
    end else begin
      tick_d = div_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      dcnt_q <= dcnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R4, R7: divider count stays inside the clamped division
  a_r7_divider_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= lim);

  // R9: the restart edge emits no tick
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_o);

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int unsigned NUM_CH       = 5,
  parameter int unsigned SPLIT_CH     = 2,
  parameter int unsigned PSC_W        = 8,
  parameter int unsigned SEL_W        = 4,
  parameter int unsigned DIV_BASE     = 1,
  parameter int unsigned DIV_MAX_LOG2 = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 'h0010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*PSC_W-1:0]      cfg_prescale,
  input  logic [NUM_CH*SEL_W-1:0] cfg_select,
  input  logic                    ext_clk0,
  input  logic                    ext_clk1,
  output logic [NUM_CH-1:0]       tick
);

  localparam int unsigned NGRP = 2;

  logic [NGRP-1:0] pre_pulse;
  logic [NGRP-1:0] pre_restart;
  logic [NGRP-1:0] ext_rise;
  logic [NGRP-1:0] ext_in;

  assign ext_in = {ext_clk1, ext_clk0};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    ptg_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk       (clk),
      .rst_n     (rst_n),
      .psc_i     (cfg_prescale[g*PSC_W +: PSC_W]),
      .restart_o (pre_restart[g]),
      .pulse_o   (pre_pulse[g])
    );

    ptg_ext_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_i  (ext_in[g]),
      .rise_o (ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = group_of(c, SPLIT_CH);

    ptg_chan_div #(
      .SEL_W        (SEL_W),
      .DIV_BASE     (DIV_BASE),
      .DIV_MAX_LOG2 (DIV_MAX_LOG2),
      .EXT_MASK     (EXT_MASK)
    ) u_div (
      .clk           (clk),
      .rst_n         (rst_n),
      .sel_i         (cfg_select[c*SEL_W +: SEL_W]),
      .pre_pulse_i   (pre_pulse[GRP]),
      .pre_restart_i (pre_restart[GRP]),
      .ext_rise_i    (ext_rise[GRP]),
      .tick_o        (tick[c])
    );

    if (DIV_BASE > 0) begin : g_pulse_chk
      // R8: a tick never stays high for two cycles
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick[c] |=> !tick[c]);
    end
  end

endmodule

// File: tb/pwm_tick_gen_test.sv
module pwm_tick_gen_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_prescale;
  logic [19:0] cfg_select;
  logic        ext_clk0;
  logic        ext_clk1;
  logic [4:0]  tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  pwm_tick_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_prescale (cfg_prescale),
    .cfg_select   (cfg_select),
    .ext_clk0     (ext_clk0),
    .ext_clk1     (ext_clk1),
    .tick         (tick)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // external clocks: period 6 and 10 base cycles
  int e0c = 0;
  int e1c = 0;
  initial begin
    ext_clk0 = 1'b0;
    ext_clk1 = 1'b0;
  end
  always @(negedge clk) begin
    e0c <= (e0c == 2) ? 0 : e0c + 1;
    if (e0c == 2) ext_clk0 <= ~ext_clk0;
    e1c <= (e1c == 4) ? 0 : e1c + 1;
    if (e1c == 4) ext_clk1 <= ~ext_clk1;
  end

  typedef struct packed {
    logic [15:0]     psc;
    logic [19:0]     sel;
    logic [4:0][7:0] per;   // per[c] = expected period of channel c
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{psc: 16'h0000, sel: 20'h00000, per: {8'd2,  8'd2,  8'd2,  8'd2,  8'd2 }},
    '{psc: 16'h0102, sel: 20'h13021, per: {8'd8,  8'd32, 8'd4,  8'd24, 8'd12}},
    '{psc: 16'h0503, sel: 20'h42404, per: {8'd10, 8'd48, 8'd10, 8'd8,  8'd6 }},
    '{psc: 16'h0000, sel: 20'h053F7, per: {8'd2,  8'd16, 8'd16, 8'd16, 8'd16}},
    '{psc: 16'h0400, sel: 20'h11111, per: {8'd20, 8'd20, 8'd20, 8'd4,  8'd4 }}
  };

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // period between two consecutive ticks; -1 on timeout
  task automatic measure(input int ch, output int per, output int width_ok);
    int t;
    per = -1;
    width_ok = 1;
    t = 0;
    while (tick[ch] !== 1'b1 && t < 400) begin
      @(negedge clk);
      t++;
    end
    if (t >= 400) return;
    @(negedge clk);
    if (tick[ch] !== 1'b0) width_ok = 0;
    t = 1;
    while (tick[ch] !== 1'b1 && t < 400) begin
      @(negedge clk);
      t++;
    end
    if (t < 400) per = t;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int per;
    int wok;
    int first;
    rst_n        = 1'b0;
    cfg_prescale = 16'h0000;
    cfg_select   = 20'h00000;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(tick), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      cfg_prescale = VECS[v].psc;
      cfg_select   = VECS[v].sel;
      repeat (100) @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        measure(c, per, wok);
        check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d ch %0d period", v, c),
              per, int'(VECS[v].per[c]));
        check($sformatf("R8 vec %0d ch %0d width", v, c), wok, 1);
      end
    end

    // R9: selector-only change on channel 1, P0 = 0, code 1 -> 2 : first tick at edge 8
    cfg_prescale = 16'h0400;
    cfg_select   = 20'h11111;
    repeat (50) @(negedge clk);
    cfg_select = 20'h11121;
    first = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (first < 0 && tick[1] === 1'b1) first = k;
    end
    check("R9 selector restart first tick", first, 8);

    // R9: prescaler change P0 0 -> 2 with channel 0 code 1 : first tick at edge 12
    cfg_prescale = 16'h0402;
    first = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (first < 0 && tick[0] === 1'b1) first = k;
    end
    check("R9 prescaler restart first tick", first, 12);

    // R1: asserting reset mid-run clears all ticks
    cfg_prescale = 16'h0000;
    cfg_select   = 20'h00000;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 held reset", int'(tick), 0);
    end
    rst_n = 1'b1;

    finish_run();
  end

endmodule